// File: doc/BRIEF.md
# Prioritizing Interrupt Controller with Index Access

This block collects a parameterised set of system interrupt lines and presents them to a processor as one host interrupt request. Each line is synchronised, then turned into a latched pending bit by a per-line detector that can be set to respond to a rising edge, a falling edge, a high level or a low level. Software controls the block through a simple 32-bit register bus. Pending bits and enable bits can be changed in two ways. Writing a line number to a dedicated index register touches only that one line, with no read-modify-write. Writing a mask to a banked word register acts on 32 lines at once.

Every line is given a channel number. Among the lines that are both pending and enabled, a resolver picks a winner: the lowest channel number wins, and a tie goes to the lowest line number. Software reads the winner from a single readout register, which also carries a flag meaning "nothing pending". The host request is raised only when a global enable, a host enable and at least one enabled pending line are all present. The register bus is plain control with no back-pressure. A read returns its data one cycle later, and a write takes effect at the clock edge where it is presented.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset, all enable bits, pending bits, the global enable and the host enable are 0. Every polarity bit is 1, every type bit is 0 and every channel number is 0. The readout register at 0x80 reads 0x8000_0000.
- R2: A line with type 0 is level-sensitive. Its active level is high when polarity is 1 and low when polarity is 0. Its pending bit is set while the synchronised input sits at the active level, and it comes back after a clear if that level persists. Pending bits are set whether or not the line is enabled.
- R3: A line with type 1 is edge-sensitive. With polarity 1 it latches on a rising edge, and with polarity 0 on a falling edge. The pending bit stays set after the input returns until software clears it. The opposite edge sets nothing.
- R4: Writing N to 0x28 sets enable N, and writing N to 0x2C clears enable N. Writing N to 0x24 clears pending bit N. Other lines are unaffected, and an N at or above the line count changes nothing.
- R5: Banked words use stride 4, and word w covers lines 32w..32w+31, with line 32w+b in bit b. Writing 1s to 0x280+4w clears pending bits, writing 1s to 0x300+4w sets enables, and writing 1s to 0x380+4w clears enables. Reading 0x280+4w returns the pending bits. Reading either 0x300+4w or 0x380+4w returns the enables.
- R6: Polarity words sit at 0xD00+4w and type words at 0xD80+4w. Both are fully written and read back.
- R7: Channel words sit at 0x400+4k. Line 4k+i uses byte i of word k, of which the low CH_W bits are stored and read back, and the rest of the byte reads 0.
- R8: Among lines that are pending and enabled, the one with the lowest channel number wins. Ties go to the lowest line number. The choice follows any pending, enable or channel change at once.
- R9: Reading 0x80 returns the winning line number in bits 9:0, with bit 31 clear. If no line is both pending and enabled, it returns 0x8000_0000.
- R10: host_irq_o is 1 exactly when global enable (0x10 bit 0) is 1, host enable is 1, and some line is pending and enabled.
- R11: The host enable can be written directly as bit 0 of 0x1500, and reads back there. Writing 0 to 0x34 sets it and writing 0 to 0x38 clears it. Any other index written to 0x34 or 0x38 has no effect.
- R12: Read data appears on bus_rdata_o in the cycle after bus_rd_i. Unmapped addresses, including the write-only index registers, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | NUM_SRC | Raw interrupt lines, asynchronous |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after bus_rd_i |
| host_irq_o | output | 1 | Host interrupt request |

## Verification
The bench builds the block with NUM_SRC = 40 and CH_W = 4, rather than the defaults of 64 and 8. With 40 lines the second bank word is only partly populated, so the test can show that the unused polarity bits read 0 and that an index of 40 is ignored. The narrow 4-bit channel field lets the test write a full byte and check that the upper bits are dropped. The two lines in the channel tests sit in different bank words and different channel words, so a tie, a win by channel and a reversal of the winner are all observed through the readout register.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned IDX_W = 10;

  localparam logic [31:0] A_GLB      = 32'h0000_0010;
  localparam logic [31:0] A_ST_ICLR  = 32'h0000_0024;
  localparam logic [31:0] A_EN_ISET  = 32'h0000_0028;
  localparam logic [31:0] A_EN_ICLR  = 32'h0000_002C;
  localparam logic [31:0] A_HO_ISET  = 32'h0000_0034;
  localparam logic [31:0] A_HO_ICLR  = 32'h0000_0038;
  localparam logic [31:0] A_PRIO     = 32'h0000_0080;
  localparam logic [31:0] A_ST_BANK  = 32'h0000_0280;
  localparam logic [31:0] A_EN_SBANK = 32'h0000_0300;
  localparam logic [31:0] A_EN_CBANK = 32'h0000_0380;
  localparam logic [31:0] A_CHAN     = 32'h0000_0400;
  localparam logic [31:0] A_POL      = 32'h0000_0D00;
  localparam logic [31:0] A_TYP      = 32'h0000_0D80;
  localparam logic [31:0] A_HOST     = 32'h0000_1500;

  // Encoded as {type, polarity}
  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW  = 2'b00,
    TRIG_LEVEL_HIGH = 2'b01,
    TRIG_EDGE_FALL  = 2'b10,
    TRIG_EDGE_RISE  = 2'b11
  } trig_e;

  function automatic logic [31:0] word_at(input logic [31:0] base, input int w);
    return base + 32'(4 * w);
  endfunction

endpackage

// File: rtl/irqc_src_detect.sv
module irqc_src_detect
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] typ_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o
);

  logic [NSRC-1:0] meta_q, sync_q, prev_q, hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_line
    trig_e mode;
    assign mode = trig_e'({typ_i[g], pol_i[g]});
    always_comb begin
      unique case (mode)
        TRIG_LEVEL_LOW:  hit[g] = ~sync_q[g];
        TRIG_LEVEL_HIGH: hit[g] = sync_q[g];
        TRIG_EDGE_FALL:  hit[g] = ~sync_q[g] & prev_q[g];
        TRIG_EDGE_RISE:  hit[g] = sync_q[g] & ~prev_q[g];
        default:         hit[g] = 1'b0;
      endcase
    end
  end

  // A new detection in the same cycle as a clear wins, so a held level re-arms.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_q   <= '0;
      prev_q   <= '0;
      status_o <= '0;
    end else begin
      meta_q   <= src_i;
      sync_q   <= meta_q;
      prev_q   <= sync_q;
      status_o <= (status_o & ~clr_i) | hit;
    end
  end

endmodule

// File: rtl/irqc_prio_sel.sv
module irqc_prio_sel
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 64,
  parameter int unsigned CH_W = 8
) (
  input  logic [NSRC-1:0]           pend_i,
  input  logic [NSRC-1:0][CH_W-1:0] chan_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          win_o
);

  logic [CH_W-1:0] best_ch;

  // Strict less-than keeps the lowest line number on equal channels.
  always_comb begin
    found_o = 1'b0;
    best_ch = '0;
    win_o   = '0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (pend_i[i] && (!found_o || chan_i[i] < best_ch)) begin
        found_o = 1'b1;
        best_ch = chan_i[i];
        win_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned CH_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               host_irq_o
);

  localparam int unsigned BANK_BITS = 32;
  localparam int unsigned CH_PER_W  = 4;

  logic [31:0]                  a32;
  logic [NUM_SRC-1:0]           st_q, st_clr, en_q, en_d, pol_q, pol_d, typ_q, typ_d, pend;
  logic [NUM_SRC-1:0][CH_W-1:0] chan_q, chan_d;
  logic                         gen_q, gen_d, hen_q, hen_d;
  logic                         sel_found;
  logic [IDX_W-1:0]             sel_win;
  logic [31:0]                  rd_c;

  assign a32 = 32'(bus_addr_i);

  irqc_src_detect #(.NSRC(NUM_SRC)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (irq_src_i),
    .pol_i    (pol_q),
    .typ_i    (typ_q),
    .clr_i    (st_clr),
    .status_o (st_q)
  );

  assign pend = st_q & en_q;

  irqc_prio_sel #(.NSRC(NUM_SRC), .CH_W(CH_W)) u_prio (
    .pend_i  (pend),
    .chan_i  (chan_q),
    .found_o (sel_found),
    .win_o   (sel_win)
  );

  assign host_irq_o = gen_q & hen_q & (|pend);

  // Write decode
  always_comb begin
    st_clr = '0;
    en_d   = en_q;
    pol_d  = pol_q;
    typ_d  = typ_q;
    chan_d = chan_q;
    gen_d  = gen_q;
    hen_d  = hen_q;
    if (bus_wr_i) begin
      if (a32 == A_GLB)  gen_d = bus_wdata_i[0];
      if (a32 == A_HOST) hen_d = bus_wdata_i[0];
      if (a32 == A_HO_ISET && bus_wdata_i == 32'd0) hen_d = 1'b1;
      if (a32 == A_HO_ICLR && bus_wdata_i == 32'd0) hen_d = 1'b0;
      for (int i = 0; i < int'(NUM_SRC); i++) begin
        if (bus_wdata_i == 32'(i)) begin
          if (a32 == A_ST_ICLR) st_clr[i] = 1'b1;
          if (a32 == A_EN_ISET) en_d[i]   = 1'b1;
          if (a32 == A_EN_ICLR) en_d[i]   = 1'b0;
        end
        if (a32 == word_at(A_ST_BANK, i / BANK_BITS) && bus_wdata_i[i % BANK_BITS])
          st_clr[i] = 1'b1;
        if (a32 == word_at(A_EN_SBANK, i / BANK_BITS) && bus_wdata_i[i % BANK_BITS])
          en_d[i] = 1'b1;
        if (a32 == word_at(A_EN_CBANK, i / BANK_BITS) && bus_wdata_i[i % BANK_BITS])
          en_d[i] = 1'b0;
        if (a32 == word_at(A_POL, i / BANK_BITS)) pol_d[i] = bus_wdata_i[i % BANK_BITS];
        if (a32 == word_at(A_TYP, i / BANK_BITS)) typ_d[i] = bus_wdata_i[i % BANK_BITS];
        if (a32 == word_at(A_CHAN, i / CH_PER_W))
          chan_d[i] = bus_wdata_i[8*(i % CH_PER_W) +: CH_W];
      end
    end
  end

  // Read decode
  always_comb begin
    rd_c = '0;
    if (a32 == A_GLB)  rd_c[0] = gen_q;
    if (a32 == A_HOST) rd_c[0] = hen_q;
    if (a32 == A_PRIO) begin
      rd_c[31]        = ~sel_found;
      rd_c[IDX_W-1:0] = sel_found ? sel_win : '0;
    end
    for (int i = 0; i < int'(NUM_SRC); i++) begin
      if (a32 == word_at(A_ST_BANK, i / BANK_BITS)) rd_c[i % BANK_BITS] = st_q[i];
      if (a32 == word_at(A_EN_SBANK, i / BANK_BITS) || a32 == word_at(A_EN_CBANK, i / BANK_BITS))
        rd_c[i % BANK_BITS] = en_q[i];
      if (a32 == word_at(A_POL, i / BANK_BITS)) rd_c[i % BANK_BITS] = pol_q[i];
      if (a32 == word_at(A_TYP, i / BANK_BITS)) rd_c[i % BANK_BITS] = typ_q[i];
      if (a32 == word_at(A_CHAN, i / CH_PER_W)) rd_c[8*(i % CH_PER_W) +: CH_W] = chan_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= '0;
      pol_q       <= '1;
      typ_q       <= '0;
      chan_q      <= '0;
      gen_q       <= 1'b0;
      hen_q       <= 1'b0;
      bus_rdata_o <= '0;
    end else begin
      en_q        <= en_d;
      pol_q       <= pol_d;
      typ_q       <= typ_d;
      chan_q      <= chan_d;
      gen_q       <= gen_d;
      hen_q       <= hen_d;
      bus_rdata_o <= bus_rd_i ? rd_c : '0;
    end
  end

endmodule

// File: rtl/irqc_ctrl_chk.sv
module irqc_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC   = 64,
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   st_q,
  input logic              gen_q,
  input logic              hen_q,
  input logic              sel_found,
  input logic [IDX_W-1:0]  sel_win,
  input logic              host_irq_o
);

  logic [31:0]     a32;
  logic            lw_set, lw_clr;
  logic [31:0]     lw_idx;
  logic [NSRC-1:0] en_sh, pend_sh;

  assign a32     = 32'(bus_addr_i);
  assign en_sh   = en_q >> lw_idx;
  assign pend_sh = (st_q & en_q) >> sel_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lw_set <= 1'b0;
      lw_clr <= 1'b0;
      lw_idx <= '0;
    end else begin
      lw_set <= bus_wr_i && a32 == A_EN_ISET && bus_wdata_i < NSRC;
      lw_clr <= bus_wr_i && a32 == A_EN_ICLR && bus_wdata_i < NSRC;
      lw_idx <= bus_wdata_i;
    end
  end

  p_idx_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lw_set |-> en_sh[0]);

  p_idx_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lw_clr |-> !en_sh[0]);

  p_idx_onebit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_set || lw_clr) |-> $countones(en_q ^ $past(en_q)) <= 1);

  p_win_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found |-> pend_sh[0]);

  p_none_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_found |-> ((st_q & en_q) == '0));

  p_host_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_o |-> (gen_q && hen_q && sel_found));

  p_host_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && hen_q && sel_found) |-> host_irq_o);

endmodule

bind irqc_ctrl irqc_ctrl_chk #(.NSRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .en_q        (en_q),
  .st_q        (st_q),
  .gen_q       (gen_q),
  .hen_q       (hen_q),
  .sel_found   (sel_found),
  .sel_win     (sel_win),
  .host_irq_o  (host_irq_o)
);

// File: tb/irqc_ctrl_tb.sv
`timescale 1ns/1ps
module irqc_ctrl_tb;

  localparam int unsigned NS = 40;
  localparam int unsigned AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_src = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          host_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          rd_pend = 1'b0;

  always #2 clk = ~clk;

  irqc_ctrl #(.NUM_SRC(NS), .ADDR_W(AW), .CH_W(4)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_src_i   (irq_src),
    .bus_wr_i    (bus_wr),
    .bus_rd_i    (bus_rd),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .host_irq_o  (host_irq)
  );

  // Monitor: pops the expected item for each read response.
  always @(negedge clk) begin
    if (rd_pend) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data: actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
    rd_pend = bus_rd;
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a[AW-1:0];
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (host_irq !== e) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", t, host_irq, e);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1 host idle");
    rd(32'h80,  32'h8000_0000, "R1 readout none");
    rd(32'h10,  32'h0, "R1 global enable");
    rd(32'h1500, 32'h0, "R1 host enable");
    rd(32'hD00, 32'hFFFF_FFFF, "R1 polarity word0");
    rd(32'hD04, 32'h0000_00FF, "R1 polarity word1 partial");
    rd(32'hD80, 32'h0, "R1 type word0");
    rd(32'h380, 32'h0, "R1 enables");
    rd(32'h424, 32'h0, "R1 channel word9");

    // R2 level high, set regardless of enable
    irq_src[3] = 1'b1; settle();
    rd(32'h280, 32'h8, "R2 level status unenabled");
    rd(32'h80, 32'h8000_0000, "R9 none while not enabled");
    wr(32'h28, 32'd3);
    wr(32'h10, 32'd1);
    chk_irq(1'b0, "R10 no host enable");
    wr(32'h34, 32'd0);
    chk_irq(1'b1, "R10 all gates open");
    rd(32'h80, 32'd3, "R9 readout line 3");
    wr(32'h24, 32'd3); settle();
    rd(32'h280, 32'h8, "R2 level re-asserts after clear");
    irq_src[3] = 1'b0; settle();
    rd(32'h280, 32'h8, "R2 status held after level drops");
    wr(32'h24, 32'd3); settle();
    rd(32'h280, 32'h0, "R4 index clear of status");
    chk_irq(1'b0, "R10 nothing pending");

    // R3 rising edge on line 5
    wr(32'hD80, 32'h20);
    rd(32'hD80, 32'h20, "R6 type word readback");
    irq_src[5] = 1'b1; repeat (3) @(posedge clk);
    irq_src[5] = 1'b0; settle();
    rd(32'h280, 32'h20, "R3 rising edge latched");
    chk_irq(1'b0, "R10 line 5 not enabled");
    wr(32'h28, 32'd5);
    chk_irq(1'b1, "R10 line 5 enabled");
    rd(32'h80, 32'd5, "R9 readout line 5");
    wr(32'h280, 32'h20); settle();
    rd(32'h280, 32'h0, "R5 bank status clear");
    chk_irq(1'b0, "R10 after bank clear");

    // R3 falling edge on line 33
    wr(32'hD84, 32'h2);
    wr(32'hD04, 32'hFD);
    rd(32'hD04, 32'hFD, "R6 polarity word readback");
    irq_src[33] = 1'b1; settle();
    rd(32'h284, 32'h0, "R3 opposite edge ignored");
    irq_src[33] = 1'b0; settle();
    rd(32'h284, 32'h2, "R3 falling edge latched");

    // R8 priority
    wr(32'h28, 32'd33);
    rd(32'h80, 32'd33, "R8 single pending");
    irq_src[3] = 1'b1; settle();
    rd(32'h80, 32'd3, "R8 tie to lower line");
    wr(32'h400, 32'hF200_0000);
    rd(32'h400, 32'h0200_0000, "R7 channel byte masked to CH_W");
    rd(32'h80, 32'd33, "R8 lower channel wins");
    wr(32'h420, 32'h0000_0500);
    rd(32'h420, 32'h0000_0500, "R7 channel word8 byte1");
    rd(32'h80, 32'd3, "R8 winner follows channel change");
    wr(32'h2C, 32'd3);
    rd(32'h80, 32'd33, "R4 index clear of enable");
    wr(32'h384, 32'h2);
    rd(32'h80, 32'h8000_0000, "R5 bank enable clear");
    chk_irq(1'b0, "R10 none enabled");

    // R10 / R11 gating
    wr(32'h304, 32'h2);
    chk_irq(1'b1, "R5 bank enable set");
    wr(32'h10, 32'd0);
    chk_irq(1'b0, "R10 global gate");
    wr(32'h10, 32'd1);
    chk_irq(1'b1, "R10 global reopened");
    wr(32'h1500, 32'd0);
    chk_irq(1'b0, "R11 direct host disable");
    rd(32'h1500, 32'h0, "R11 host readback 0");
    wr(32'h34, 32'd1);
    chk_irq(1'b0, "R11 other host index ignored");
    wr(32'h1500, 32'd1);
    chk_irq(1'b1, "R11 direct host enable");
    rd(32'h1500, 32'h1, "R11 host readback 1");

    // R4 out-of-range, R12 unmapped
    wr(32'h28, 32'd40);
    rd(32'h384, 32'h2, "R4 out-of-range index ignored");
    rd(32'h380, 32'h20, "R5 enable word0");
    rd(32'h1000, 32'h0, "R12 unmapped reads 0");
    rd(32'h24, 32'h0, "R12 index register reads 0");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard: actual=%0d left expected=0", exp_q.size());
    end
    finish_up();
  end

endmodule